// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block is a small performance monitoring unit that sits beside a data mover and counts events that the mover reports on an event bus. Every clock cycle the bus may carry one event, tagged with a category, an event code and five attributes: work queue, traffic class, page size, transfer size and engine. Each counter in the bank is programmed through a 64-bit register port with the category and code it should count. Five per-counter filter registers can narrow counting to events whose attributes overlap a chosen bit mask.

Counters wrap at their configured width and leave a sticky overflow flag behind. Software clears a flag by writing a one to it. The interrupt line is high while a flagged counter has its overflow interrupt enabled. A single freeze control stops or resumes every counter at once. A reset register offers two separate actions: one clears the programming of all counters, the other clears their values. A read-only capability word describes the bank so that software can size itself to it.

Register map (byte addresses, 64-bit words, address bits 2:0 ignored): 0x000 capability, 0x008 freeze, 0x010 reset actions, 0x018 overflow status. Counter i owns the 64-byte slot at 0x100 + 0x40*i. In that slot, +0x00 is the configuration, +0x08 the value (read only), +0x10 the work-queue filter, +0x18 the traffic-class filter, +0x20 the page-size filter, +0x28 the transfer-size filter and +0x30 the engine filter.

Top module: `pmu_counter_bank`

## Requirements
- R1: After reset every counter value, configuration word, filter and overflow status bit reads zero, the freeze register reads zero, and irq is low.
- R2: The configuration word has the enable in bit 0, the overflow interrupt enable in bit 1, the category in bits 7:4 and the event code in bits 35:8. A counter adds exactly one per cycle in which ev_valid is high, its enable is set, and the event category and code both equal its programmed values. Otherwise it holds.
- R3: Each filter is stored at its attribute width: work queue 32 bits, traffic class 8, page size 4, transfer size 8, engine 8. Higher write bits are dropped on readback. A zero filter passes every event. A nonzero filter passes an event only when filter AND attribute is nonzero. An event is counted only when all five filters pass.
- R4: A counter holds 16 bits by default and wraps from all ones to zero. That wrap sets the counter's bit (bit i for counter i) in the overflow status register.
- R5: Writing 1 to bit 0 of the freeze register stops every counter. Writing 0 there lets them resume. The freeze register reads back bit 0.
- R6: Writing the overflow status register clears each bit written as 1 and leaves bits written as 0 unchanged. A set bit stays set until cleared. If a wrap and a clear hit the same bit in one cycle, the bit ends up set.
- R7: irq is high whenever some overflow status bit is set for a counter whose overflow interrupt enable is set. It is high in the cycle after such a wrap and low once no such bit remains.
- R8: Writing the reset register with bit 0 set clears all configuration words and filters but keeps counter values. Writing it with bit 1 set clears all counter values but keeps configuration.
- R9: The capability word reads the counter count in bits 7:0, the counter width in bits 15:8, overflow interrupt support in bit 16, freeze support in bit 17, the number of event categories in bits 23:20 and the supported filter bitmap in bits 28:24. With the defaults it reads 0x1F431004.
- R10: reg_rdata is updated one clock after a cycle with reg_rd high and holds otherwise. A counter value reads as a 64-bit word with all bits above the counter width zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after reg_rd |
| ev_valid | input | 1 | An event is present this cycle |
| ev_cat | input | 4 | Event category |
| ev_code | input | 28 | Event code |
| ev_wq | input | 32 | Work-queue attribute |
| ev_tc | input | 8 | Traffic-class attribute |
| ev_pgsz | input | 4 | Page-size attribute |
| ev_xsz | input | 8 | Transfer-size attribute |
| ev_eng | input | 8 | Engine attribute |
| irq | output | 1 | Overflow interrupt, level |

## Verification
A wrong match decision or filter value shows up in the counter value on the very next read after one event, so the bench reads the counter after every single event of its pattern table. A corrupted overflow flag or interrupt mask shows on irq one cycle after the wrap and in the status word. The wrap itself takes 65536 matching events to reach and is driven in full on two counters, once with a competing clear. Damage from the split reset actions is found by reading back both the configuration and the value after each action.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int FLT_NUM = 5;
  localparam int FLT_WQ  = 0;
  localparam int FLT_TC  = 1;
  localparam int FLT_PG  = 2;
  localparam int FLT_XS  = 3;
  localparam int FLT_ENG = 4;

  localparam int CFG_EN      = 0;
  localparam int CFG_IE      = 1;
  localparam int CFG_CAT_LO  = 4;
  localparam int CFG_CODE_LO = 8;

  localparam int RST_CFG = 0;
  localparam int RST_CNT = 1;

  localparam logic [8:0] W_CAP  = 9'd0;
  localparam logic [8:0] W_FRZ  = 9'd1;
  localparam logic [8:0] W_RST  = 9'd2;
  localparam logic [8:0] W_OVF  = 9'd3;
  localparam logic [8:0] W_CNT0 = 9'd32;

  typedef struct packed {
    logic [3:0]  cat;
    logic [27:0] code;
    logic [31:0] wq;
    logic [7:0]  tc;
    logic [3:0]  pg;
    logic [7:0]  xs;
    logic [7:0]  eng;
  } pmu_event_t;

  function automatic int flt_width(input int k);
    case (k)
      FLT_WQ:  return 32;
      FLT_PG:  return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic flt_pass(input logic [31:0] f, input logic [31:0] a);
    return (f == 32'd0) || ((f & a) != 32'd0);
  endfunction

  function automatic logic [FLT_NUM-1:0][31:0] ev_attrs(input pmu_event_t e);
    logic [FLT_NUM-1:0][31:0] v;
    v[FLT_WQ]  = e.wq;
    v[FLT_TC]  = 32'(e.tc);
    v[FLT_PG]  = 32'(e.pg);
    v[FLT_XS]  = 32'(e.xs);
    v[FLT_ENG] = 32'(e.eng);
    return v;
  endfunction

  function automatic logic [63:0] cap_word(input int n, input int w, input int ncat,
                                           input logic [FLT_NUM-1:0] fm);
    logic [63:0] c;
    c        = '0;
    c[7:0]   = 8'(n);
    c[15:8]  = 8'(w);
    c[16]    = 1'b1;
    c[17]    = 1'b1;
    c[23:20] = 4'(ncat);
    c[28:24] = fm;
    return c;
  endfunction

endpackage

// File: rtl/pmu_filter_match.sv
module pmu_filter_match
  import pmu_pkg::*;
(
  input  logic [FLT_NUM-1:0][31:0] flt,
  input  logic [FLT_NUM-1:0][31:0] attr,
  output logic                     pass
);

  logic [FLT_NUM-1:0] ok;

  for (genvar k = 0; k < FLT_NUM; k++) begin : g_chk
    assign ok[k] = flt_pass(flt[k], attr[k]);
  end

  assign pass = &ok;

endmodule

// File: rtl/pmu_counter_slice.sv
module pmu_counter_slice
  import pmu_pkg::*;
#(
  parameter int                 CNT_W    = 16,
  parameter logic [FLT_NUM-1:0] FLT_MASK = 5'h1F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [FLT_NUM-1:0]       flt_we,
  input  logic [63:0]              wdata,
  input  logic                     cfg_clr,
  input  logic                     cnt_clr,
  input  logic                     frozen,
  input  logic                     ev_valid,
  input  pmu_event_t               ev,
  output logic [63:0]              cfg_rd,
  output logic [FLT_NUM-1:0][31:0] flt_rd,
  output logic [CNT_W-1:0]         count_q,
  output logic                     ovf_set,
  output logic                     irq_en
);

  logic        en_q;
  logic        ie_q;
  logic [3:0]  cat_q;
  logic [27:0] code_q;
  logic        flt_ok;
  logic        ev_hit;
  logic        wrap;
  logic [FLT_NUM-1:0][31:0] attr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      cat_q  <= '0;
      code_q <= '0;
    end else if (cfg_clr) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      cat_q  <= '0;
      code_q <= '0;
    end else if (cfg_we) begin
      en_q   <= wdata[CFG_EN];
      ie_q   <= wdata[CFG_IE];
      cat_q  <= wdata[CFG_CAT_LO +: 4];
      code_q <= wdata[CFG_CODE_LO +: 28];
    end
  end

  always_comb begin
    cfg_rd                     = '0;
    cfg_rd[CFG_EN]             = en_q;
    cfg_rd[CFG_IE]             = ie_q;
    cfg_rd[CFG_CAT_LO +: 4]    = cat_q;
    cfg_rd[CFG_CODE_LO +: 28]  = code_q;
  end

  for (genvar k = 0; k < FLT_NUM; k++) begin : g_flt
    if (FLT_MASK[k]) begin : g_on
      localparam int FW = flt_width(k);
      logic [FW-1:0] fv;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          fv <= '0;
        else if (cfg_clr)    fv <= '0;
        else if (flt_we[k])  fv <= wdata[FW-1:0];
      end
      assign flt_rd[k] = 32'(fv);
    end else begin : g_off
      assign flt_rd[k] = 32'd0;
    end
  end

  assign attr_w = ev_attrs(ev);

  pmu_filter_match u_match (
    .flt  (flt_rd),
    .attr (attr_w),
    .pass (flt_ok)
  );

  assign ev_hit  = ev_valid && en_q && !frozen && (ev.cat == cat_q) &&
                   (ev.code == code_q) && flt_ok;
  assign wrap    = ev_hit && (count_q == {CNT_W{1'b1}});
  assign ovf_set = wrap && !cnt_clr;
  assign irq_en  = ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (cnt_clr)  count_q <= '0;
    else if (ev_hit)   count_q <= count_q + 1'b1;
  end

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_clr) |=> $stable(count_q)); // R2
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !cnt_clr) |=> $stable(count_q)); // R5
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (count_q == '0)); // R8

endmodule

// File: rtl/pmu_ovf_status.sv
module pmu_ovf_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] ovf_q
);

  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~clr_eff) | set;
  end

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((ovf_q & $past(set)) == $past(set))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((ovf_q & $past(clr_mask & ~set)) == '0)); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q))); // R6

endmodule

// File: rtl/pmu_counter_bank.sv
module pmu_counter_bank
  import pmu_pkg::*;
#(
  parameter int                 NUM_CNT  = 4,
  parameter int                 CNT_W    = 16,
  parameter int                 NUM_CAT  = 4,
  parameter logic [FLT_NUM-1:0] FLT_MASK = 5'h1F,
  parameter int                 ADDR_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              ev_valid,
  input  logic [3:0]        ev_cat,
  input  logic [27:0]       ev_code,
  input  logic [31:0]       ev_wq,
  input  logic [7:0]        ev_tc,
  input  logic [3:0]        ev_pgsz,
  input  logic [7:0]        ev_xsz,
  input  logic [7:0]        ev_eng,
  output logic              irq
);

  localparam int          WORD_W = ADDR_W - 3;
  localparam logic [63:0] CAP    = cap_word(NUM_CNT, CNT_W, NUM_CAT, FLT_MASK);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] rel;
  logic              in_glob;
  logic [WORD_W-4:0] slot;
  logic [2:0]        sub;
  logic              frozen_q;
  logic              cfg_clr;
  logic              cnt_clr;
  logic              ovf_clr_we;
  logic [NUM_CNT-1:0] ovf_set;
  logic [NUM_CNT-1:0] ie_vec;
  logic [NUM_CNT-1:0] ovf_q;
  logic [63:0]        rd_mux;
  pmu_event_t         ev;

  logic [63:0]              cfg_rd [NUM_CNT];
  logic [FLT_NUM-1:0][31:0] flt_rd [NUM_CNT];
  logic [CNT_W-1:0]         cnt_rd [NUM_CNT];

  assign word    = reg_addr[ADDR_W-1:3];
  assign in_glob = (word < W_CNT0[WORD_W-1:0]);
  assign rel     = word - W_CNT0[WORD_W-1:0];
  assign slot    = rel[WORD_W-1:3];
  assign sub     = rel[2:0];

  assign cfg_clr    = reg_wr && in_glob && (word == W_RST[WORD_W-1:0]) && reg_wdata[RST_CFG];
  assign cnt_clr    = reg_wr && in_glob && (word == W_RST[WORD_W-1:0]) && reg_wdata[RST_CNT];
  assign ovf_clr_we = reg_wr && in_glob && (word == W_OVF[WORD_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frozen_q <= 1'b0;
    else if (reg_wr && in_glob && (word == W_FRZ[WORD_W-1:0]))
      frozen_q <= reg_wdata[0];
  end

  always_comb begin
    ev.cat  = ev_cat;
    ev.code = ev_code;
    ev.wq   = ev_wq;
    ev.tc   = ev_tc;
    ev.pg   = ev_pgsz;
    ev.xs   = ev_xsz;
    ev.eng  = ev_eng;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic               sel;
    logic               cfg_we;
    logic [FLT_NUM-1:0] flt_we;

    assign sel    = reg_wr && !in_glob && (slot == (WORD_W-3)'(i));
    assign cfg_we = sel && (sub == 3'd0);
    for (genvar k = 0; k < FLT_NUM; k++) begin : g_we
      assign flt_we[k] = sel && (sub == 3'(k + 2));
    end

    pmu_counter_slice #(
      .CNT_W    (CNT_W),
      .FLT_MASK (FLT_MASK)
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .flt_we   (flt_we),
      .wdata    (reg_wdata),
      .cfg_clr  (cfg_clr),
      .cnt_clr  (cnt_clr),
      .frozen   (frozen_q),
      .ev_valid (ev_valid),
      .ev       (ev),
      .cfg_rd   (cfg_rd[i]),
      .flt_rd   (flt_rd[i]),
      .count_q  (cnt_rd[i]),
      .ovf_set  (ovf_set[i]),
      .irq_en   (ie_vec[i])
    );
  end

  pmu_ovf_status #(
    .N (NUM_CNT)
  ) u_ovf (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (ovf_set),
    .clr_we   (ovf_clr_we),
    .clr_mask (reg_wdata[NUM_CNT-1:0]),
    .ovf_q    (ovf_q)
  );

  assign irq = |(ovf_q & ie_vec);

  always_comb begin
    rd_mux = '0;
    if (in_glob) begin
      case (word)
        W_CAP[WORD_W-1:0]: rd_mux = CAP;
        W_FRZ[WORD_W-1:0]: rd_mux = 64'(frozen_q);
        W_OVF[WORD_W-1:0]: rd_mux = 64'(ovf_q);
        default:           rd_mux = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CNT; i++) begin
        if (slot == (WORD_W-3)'(i)) begin
          case (sub)
            3'd0:    rd_mux = cfg_rd[i];
            3'd1:    rd_mux = 64'(cnt_rd[i]);
            3'd2:    rd_mux = 64'(flt_rd[i][FLT_WQ]);
            3'd3:    rd_mux = 64'(flt_rd[i][FLT_TC]);
            3'd4:    rd_mux = 64'(flt_rd[i][FLT_PG]);
            3'd5:    rd_mux = 64'(flt_rd[i][FLT_XS]);
            3'd6:    rd_mux = 64'(flt_rd[i][FLT_ENG]);
            default: rd_mux = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  AST_IRQ_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_set & ie_vec)) |=> irq); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R10

endmodule

// File: tb/tb_pmu_counter_bank.sv
module tb_pmu_counter_bank;

  typedef struct packed {
    logic [3:0]  cat;
    logic [27:0] code;
    logic [31:0] wq;
    logic [7:0]  tc;
    logic [3:0]  pg;
    logic [7:0]  xs;
    logic [7:0]  eng;
    logic        inc;
  } vec_t;

  // counter 0 filters: wq=0x6, pg=0x3, eng=0x80, tc and xs left zero
  localparam vec_t VECS [8] = '{
    '{4'd3, 28'h55, 32'h2,        8'h00, 4'h1, 8'h00, 8'h80, 1'b1},
    '{4'd3, 28'h55, 32'h1,        8'h00, 4'h1, 8'h00, 8'h80, 1'b0},
    '{4'd2, 28'h55, 32'h2,        8'h00, 4'h1, 8'h00, 8'h80, 1'b0},
    '{4'd3, 28'h54, 32'h2,        8'h00, 4'h1, 8'h00, 8'h80, 1'b0},
    '{4'd3, 28'h55, 32'h4,        8'hFF, 4'h2, 8'hFF, 8'h80, 1'b1},
    '{4'd3, 28'h55, 32'h6,        8'h00, 4'h4, 8'h00, 8'h80, 1'b0},
    '{4'd3, 28'h55, 32'h6,        8'h00, 4'h3, 8'h00, 8'h7F, 1'b0},
    '{4'd3, 28'h55, 32'hFFFFFFFF, 8'h01, 4'hF, 8'h01, 8'hFF, 1'b1}
  };

  localparam logic [11:0] A_CAP = 12'h000;
  localparam logic [11:0] A_FRZ = 12'h008;
  localparam logic [11:0] A_RST = 12'h010;
  localparam logic [11:0] A_OVF = 12'h018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_cat = '0;
  logic [27:0] ev_code = '0;
  logic [31:0] ev_wq = '0;
  logic [7:0]  ev_tc = '0;
  logic [3:0]  ev_pgsz = '0;
  logic [7:0]  ev_xsz = '0;
  logic [7:0]  ev_eng = '0;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] rv;
  logic [63:0] exp_cnt;

  always #10 clk = ~clk;

  pmu_counter_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_valid(ev_valid), .ev_cat(ev_cat), .ev_code(ev_code), .ev_wq(ev_wq),
    .ev_tc(ev_tc), .ev_pgsz(ev_pgsz), .ev_xsz(ev_xsz), .ev_eng(ev_eng),
    .irq(irq)
  );

  function automatic logic [11:0] ca(input int i, input int r);
    return 12'(12'h100 + i * 12'h40 + r * 8);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_ev(input logic [3:0] c, input logic [27:0] code, input logic [31:0] wq,
                        input logic [7:0] tc, input logic [3:0] pg, input logic [7:0] xs,
                        input logic [7:0] eng);
    ev_cat = c; ev_code = code; ev_wq = wq; ev_tc = tc; ev_pgsz = pg; ev_xsz = xs; ev_eng = eng;
  endtask

  task automatic pulse_ev(input int n);
    @(negedge clk);
    ev_valid = 1'b1;
    repeat (n) @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R9 capability layout
    rd(A_CAP, rv);     chk("R9 capability", rv, 64'h1F43_1004);
    rd(ca(0, 0), rv);  chk("R1 cfg0 after reset", rv, 64'h0);
    rd(ca(2, 1), rv);  chk("R1 count2 after reset", rv, 64'h0);
    rd(ca(1, 2), rv);  chk("R1 wq filter1 after reset", rv, 64'h0);
    rd(A_OVF, rv);     chk("R1 ovf after reset", rv, 64'h0);
    rd(A_FRZ, rv);     chk("R1 freeze after reset", rv, 64'h0);
    chk("R1 irq after reset", 64'(irq), 64'h0);

    // counter 0: en, cat 3, code 0x55; filters wq 6, pg 3, eng 0x80
    wr(ca(0, 0), 64'h5531);
    wr(ca(0, 2), 64'h6);
    wr(ca(0, 4), 64'h3);
    wr(ca(0, 6), 64'h80);
    rd(ca(0, 0), rv);  chk("R2 cfg0 readback", rv, 64'h5531);

    // R2 R3 table walk
    exp_cnt = 0;
    for (int v = 0; v < 8; v++) begin
      set_ev(VECS[v].cat, VECS[v].code, VECS[v].wq, VECS[v].tc, VECS[v].pg,
             VECS[v].xs, VECS[v].eng);
      pulse_ev(1);
      exp_cnt = exp_cnt + 64'(VECS[v].inc);
      rd(ca(0, 1), rv);
      chk($sformatf("R2/R3 vector %0d count", v), rv, exp_cnt);
    end

    // R2 disabled counter holds
    set_ev(4'd3, 28'h55, 32'h2, 8'h0, 4'h1, 8'h0, 8'h80);
    wr(ca(0, 0), 64'h5530);
    pulse_ev(1);
    rd(ca(0, 1), rv);  chk("R2 disabled holds", rv, 64'd3);
    wr(ca(0, 0), 64'h5531);

    // R5 freeze and resume
    wr(A_FRZ, 64'h1);
    rd(A_FRZ, rv);     chk("R5 freeze readback", rv, 64'h1);
    pulse_ev(2);
    rd(ca(0, 1), rv);  chk("R5 frozen holds", rv, 64'd3);
    wr(A_FRZ, 64'h0);
    pulse_ev(1);
    rd(ca(0, 1), rv);  chk("R5 resumed counts", rv, 64'd4);

    // R8 counter reset keeps cfg
    wr(A_RST, 64'h2);
    rd(ca(0, 1), rv);  chk("R8 counter reset value", rv, 64'd0);
    rd(ca(0, 0), rv);  chk("R8 counter reset keeps cfg", rv, 64'h5531);
    pulse_ev(2);
    // R8 config reset keeps value
    wr(A_RST, 64'h1);
    rd(ca(0, 0), rv);  chk("R8 config reset cfg", rv, 64'h0);
    rd(ca(0, 2), rv);  chk("R8 config reset filter", rv, 64'h0);
    rd(ca(0, 1), rv);  chk("R8 config reset keeps value", rv, 64'd2);

    // R3 filter stored at attribute width
    wr(ca(3, 3), 64'hABC);
    rd(ca(3, 3), rv);  chk("R3 tc filter width", rv, 64'hBC);
    wr(ca(3, 3), 64'h0);

    // R4 R7 wrap: counter1 with irq enable, counter2 without
    wr(ca(1, 0), 64'h0713);
    wr(ca(2, 0), 64'h0711);
    set_ev(4'd1, 28'h7, 32'h0, 8'h0, 4'h0, 8'h0, 8'h0);
    pulse_ev(65535);
    rd(ca(1, 1), rv);  chk("R4 count at max", rv, 64'hFFFF);
    rd(A_OVF, rv);     chk("R4 no ovf before wrap", rv, 64'h0);
    chk("R7 irq low before wrap", 64'(irq), 64'h0);
    pulse_ev(1);
    chk("R7 irq high after wrap", 64'(irq), 64'h1);
    rd(ca(1, 1), rv);  chk("R4 R10 wrapped to zero", rv, 64'h0);
    rd(A_OVF, rv);     chk("R4 ovf bits set", rv, 64'h6);

    // R6 W1C and R7 masking
    wr(A_OVF, 64'h2);
    rd(A_OVF, rv);     chk("R6 clear bit1", rv, 64'h4);
    chk("R7 irq low with masked bit only", 64'(irq), 64'h0);
    wr(A_OVF, 64'h0);
    rd(A_OVF, rv);     chk("R6 zero write no effect", rv, 64'h4);
    wr(A_OVF, 64'h4);
    rd(A_OVF, rv);     chk("R6 clear bit2", rv, 64'h0);

    // R6 set wins over same-cycle clear
    wr(ca(1, 0), 64'h0712);
    pulse_ev(65535);
    rd(ca(2, 1), rv);  chk("R4 count2 at max", rv, 64'hFFFF);
    @(negedge clk);
    ev_valid = 1'b1; reg_wr = 1'b1; reg_addr = A_OVF; reg_wdata = 64'h4;
    @(negedge clk);
    ev_valid = 1'b0; reg_wr = 1'b0;
    rd(A_OVF, rv);     chk("R6 set wins over clear", rv, 64'h4);
    rd(ca(1, 1), rv);  chk("R2 disabled counter1 held", rv, 64'h0);

    finish_run();
  end

endmodule